// File: doc/BRIEF.md
# Radix-2 Delay-Feedback Butterfly Stage

This block is one radix-2 stage of a serial FFT/IFFT pipeline built on the single-path delay-feedback scheme. It accepts one complex sample per clock, and a load strobe marks each sample as valid. The stage works with an external delay line of `ND` words. On every loaded cycle the stage writes one word into that line and reads back the word it wrote `ND` loads earlier. A small local counter runs the whole stage, so a chain of stages needs no central controller.

Each frame has two phases. In the fill phase, the incoming sample goes into the delay line, and the stage outputs the word read from the line. That word is a difference left over from the previous butterfly phase. In the butterfly phase, the stage combines the delayed operand `a` with the incoming operand `b`. It outputs the half-scaled sum straight away and sends the half-scaled difference into the delay line, so the difference comes out one fill phase later.

The parameter `ROTATE` builds a variant of the stage. In that variant, during one quarter of every frame, the delayed operand is first turned by -j for a forward transform or by +j for an inverse transform. The runtime input `inverse` selects the sign.

The stream has no back-pressure. There is no ready signal, so the stage never stalls. A downstream consumer must accept every cycle in which `ack` is high. An upstream producer may leave gaps by holding `load` low, and the stage state then freezes.

Top module: `sdf_r2_stage`

## Requirements
- R1: Let `c` be the stage counter. When `(c / ND) mod 2 == 0` (fill phase), a loaded cycle drives `dly_wr` with the input sample, and `out` shows the word read from the delay line, unmodified.
- R2: When `(c / ND) mod 2 == 1` (butterfly phase) and no rotation applies, `out = (a + b) >>> 1` and `dly_wr = (a - b) >>> 1`, where `a` is the delay-line read word and `b` is the input sample. Each rule applies to the real and imaginary parts separately.
- R3: The counter starts at 0 and advances by one only on cycles with `load` high. Idle cycles leave the phase unchanged and keep `ack` low.
- R4: `ack` is high exactly on loaded cycles once at least `ND` loads have occurred since reset. It is low on all other cycles.
- R5: `dly_push` equals `load` on every cycle.
- R6: With `ROTATE=1`, let `Q = 4^floor(log4 ND)`. In cycles where `(c / Q) mod 4 == 3`, the butterfly uses a rotated `a`. For `inverse=0` the rotated value is (re, im) -> (im, -re), which is multiplication by -j. For `inverse=1` it is (re, im) -> (-im, re), which is multiplication by +j. With `ROTATE=0` no rotation ever happens.
- R7: Sums and differences are formed at full precision (DW+2 bits) and arithmetically shifted right by one bit. The low DW bits are kept, so full-scale operands, including -2^(DW-1), give the truncated exact result.
- R8: The counter wraps modulo the frame length: `2*ND` when `ROTATE=0`, and `max(2*ND, 4*Q)` when `ROTATE=1`. Consecutive frames need no reset.
- R9: During and right after an active-low reset, `ack` is low and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Marks the input sample as valid this cycle |
| inverse | input | 1 | 1 selects the +j rotation (inverse transform), 0 selects -j |
| in_re | input | DW | Input sample, real part, two's complement |
| in_im | input | DW | Input sample, imaginary part |
| dly_rd_re | input | DW | Word read from the delay line, real part |
| dly_rd_im | input | DW | Word read from the delay line, imaginary part |
| dly_wr_re | output | DW | Word to write into the delay line, real part |
| dly_wr_im | output | DW | Word to write into the delay line, imaginary part |
| dly_push | output | 1 | Advances the delay line (read old word, write new) |
| out_re | output | DW | Output sample, real part |
| out_im | output | DW | Output sample, imaginary part |
| ack | output | 1 | Output sample is valid this cycle |

## Verification
The hardest case to reach from the ports is the rotated butterfly quarter with a delayed operand of exactly -2^(DW-1) in each rotation sign. That case needs the counter to sit in the last quarter of a frame while the delay line holds full-scale negative values written one fill phase earlier. The bench gets there by running long stretches of loads drawn from the extreme values {-32768, 32767, -1, 0}, and it switches `inverse` every sixteen loads so that both signs land in rotating quarters. Gaps in `load` are mixed into these stretches to show that idle cycles do not shift the quarter boundaries.

// File: rtl/sdf_r2_pkg.sv
package sdf_r2_pkg;
  // Rotation applied to the delayed operand before the add/subtract.
  typedef enum logic [1:0] {
    ROT_NONE  = 2'd0,
    ROT_NEG_J = 2'd1,
    ROT_POS_J = 2'd2
  } rot_sel_e;
endpackage

// File: rtl/sdf_r2_ctrl.sv
module sdf_r2_ctrl
  import sdf_r2_pkg::*;
#(
  parameter int ND     = 4,
  parameter bit ROTATE = 1'b0,
  parameter int LOG_ND = 2,
  parameter int QL     = 2,
  parameter int CW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          inverse,
  output logic [CW-1:0] cnt,
  output logic          fill,
  output logic          sb,
  output rot_sel_e      rot_sel,
  output logic          primed
);
  logic [CW-1:0] cnt_q;
  logic          primed_q;

  // Frame counter: wraps naturally at 2^CW, which is the frame length.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else if (load) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(ND - 1)) primed_q <= 1'b1;
    end
  end

  assign cnt    = cnt_q;
  assign primed = primed_q;
  assign fill   = ~cnt_q[LOG_ND];

  generate
    if (ROTATE) begin : g_rot
      assign sb = (cnt_q[QL+1:QL] == 2'b11);
    end else begin : g_plain
      assign sb = 1'b0;
    end
  endgenerate

  always_comb begin
    if (sb) rot_sel = inverse ? ROT_POS_J : ROT_NEG_J;
    else    rot_sel = ROT_NONE;
  end
endmodule

// File: rtl/sdf_r2_rotate.sv
module sdf_r2_rotate
  import sdf_r2_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] x_re,
  input  logic signed [DW-1:0] x_im,
  input  rot_sel_e             sel,
  output logic signed [DW:0]   y_re,
  output logic signed [DW:0]   y_im
);
  // One extra bit so that negating the most negative value stays exact.
  logic signed [DW:0] re_w, im_w;
  assign re_w = {x_re[DW-1], x_re};
  assign im_w = {x_im[DW-1], x_im};

  always_comb begin
    unique case (sel)
      ROT_NEG_J: begin y_re = im_w;  y_im = -re_w; end
      ROT_POS_J: begin y_re = -im_w; y_im = re_w;  end
      default:   begin y_re = re_w;  y_im = im_w;  end
    endcase
  end
endmodule

// File: rtl/sdf_r2_bfly.sv
module sdf_r2_bfly #(
  parameter int DW = 16
) (
  input  logic signed [DW:0]   a,
  input  logic signed [DW-1:0] b,
  output logic signed [DW-1:0] sum_h,
  output logic signed [DW-1:0] dif_h
);
  localparam int SW = DW + 2;
  logic signed [SW-1:0] a_x, b_x, s_full, d_full;

  assign a_x    = {a[DW], a};
  assign b_x    = {{2{b[DW-1]}}, b};
  assign s_full = a_x + b_x;
  assign d_full = a_x - b_x;
  // Arithmetic shift right by one, then keep the low DW bits.
  assign sum_h  = s_full[DW:1];
  assign dif_h  = d_full[DW:1];
endmodule

// File: rtl/sdf_r2_stage.sv
module sdf_r2_stage
  import sdf_r2_pkg::*;
#(
  parameter int DW     = 16,
  parameter int ND     = 4,
  parameter bit ROTATE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          inverse,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  input  logic [DW-1:0] dly_rd_re,
  input  logic [DW-1:0] dly_rd_im,
  output logic [DW-1:0] dly_wr_re,
  output logic [DW-1:0] dly_wr_im,
  output logic          dly_push,
  output logic [DW-1:0] out_re,
  output logic [DW-1:0] out_im,
  output logic          ack
);
  localparam int LOG_ND = $clog2(ND);
  localparam int QL     = 2 * (LOG_ND / 2);
  localparam int CW_P   = LOG_ND + 1;
  localparam int CW_R   = (CW_P > QL + 2) ? CW_P : QL + 2;
  localparam int CW     = ROTATE ? CW_R : CW_P;

  logic [CW-1:0] cnt;
  logic          fill, sb, primed;
  rot_sel_e      rot_sel;

  sdf_r2_ctrl #(
    .ND(ND), .ROTATE(ROTATE), .LOG_ND(LOG_ND), .QL(QL), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(load), .inverse(inverse),
    .cnt(cnt), .fill(fill), .sb(sb), .rot_sel(rot_sel), .primed(primed)
  );

  logic signed [1:0][DW:0]   a_op;
  logic signed [1:0][DW-1:0] b_op, s_op, d_op;

  sdf_r2_rotate #(.DW(DW)) u_rot (
    .x_re(dly_rd_re), .x_im(dly_rd_im), .sel(rot_sel),
    .y_re(a_op[0]), .y_im(a_op[1])
  );

  assign b_op[0] = in_re;
  assign b_op[1] = in_im;

  generate
    for (genvar k = 0; k < 2; k++) begin : g_lane
      sdf_r2_bfly #(.DW(DW)) u_bfly (
        .a(a_op[k]), .b(b_op[k]), .sum_h(s_op[k]), .dif_h(d_op[k])
      );
    end
  endgenerate

  assign dly_push  = load;
  assign dly_wr_re = fill ? in_re     : d_op[0];
  assign dly_wr_im = fill ? in_im     : d_op[1];
  assign out_re    = fill ? dly_rd_re : s_op[0];
  assign out_im    = fill ? dly_rd_im : s_op[1];
  assign ack       = load & primed;
endmodule

// File: rtl/sdf_r2_stage_chk.sv
module sdf_r2_stage_chk #(
  parameter int DW = 16,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic          ack,
  input logic [DW-1:0] in_re,
  input logic [DW-1:0] in_im,
  input logic [DW-1:0] dly_rd_re,
  input logic [DW-1:0] dly_rd_im,
  input logic [DW-1:0] dly_wr_re,
  input logic [DW-1:0] dly_wr_im,
  input logic [DW-1:0] out_re,
  input logic [DW-1:0] out_im,
  input logic [CW-1:0] cnt,
  input logic          fill,
  input logic          sb
);
  // R1: fill phase routes input to the line and the line to the output
  a_r1_fill_pass: assert property (@(posedge clk) disable iff (!rst_n)
    load && fill |-> dly_wr_re == in_re && dly_wr_im == in_im &&
                     out_re == dly_rd_re && out_im == dly_rd_im);

  // R3: idle cycles freeze the counter
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cnt));

  // R8: counter wraps to zero after the last position of the frame
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    load && (cnt == {CW{1'b1}}) |=> cnt == '0);

  // R4: once acknowledged, every later loaded cycle is acknowledged
  a_r4_ack_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ack) && load |-> ack);

  // R4: never acknowledge without a load
  a_r4_ack_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> load);

  // R6: rotation only during a butterfly phase
  a_r6_rot_in_bfly: assert property (@(posedge clk) disable iff (!rst_n)
    sb |-> !fill);
endmodule

bind sdf_r2_stage sdf_r2_stage_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .ack(ack),
  .in_re(in_re), .in_im(in_im), .dly_rd_re(dly_rd_re), .dly_rd_im(dly_rd_im),
  .dly_wr_re(dly_wr_re), .dly_wr_im(dly_wr_im), .out_re(out_re), .out_im(out_im),
  .cnt(cnt), .fill(fill), .sb(sb)
);

// File: tb/sdf_r2_stage_test.sv
module sdf_r2_stage_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic inverse = 1'b0;
  logic signed [15:0] in_re = '0, in_im = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // Rotation stage: ND=4, frame 16. Plain stage: ND=2, frame 4.
  logic signed [15:0] ra_re, ra_im, wa_re, wa_im, oa_re, oa_im;
  logic signed [15:0] rb_re, rb_im, wb_re, wb_im, ob_re, ob_im;
  logic pa, pb, aa, ab;

  sdf_r2_stage #(.DW(16), .ND(4), .ROTATE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .load(load), .inverse(inverse),
    .in_re(in_re), .in_im(in_im), .dly_rd_re(ra_re), .dly_rd_im(ra_im),
    .dly_wr_re(wa_re), .dly_wr_im(wa_im), .dly_push(pa),
    .out_re(oa_re), .out_im(oa_im), .ack(aa));

  sdf_r2_stage #(.DW(16), .ND(2), .ROTATE(1'b0)) uut_p (
    .clk(clk), .rst_n(rst_n), .load(load), .inverse(inverse),
    .in_re(in_re), .in_im(in_im), .dly_rd_re(rb_re), .dly_rd_im(rb_im),
    .dly_wr_re(wb_re), .dly_wr_im(wb_im), .dly_push(pb),
    .out_re(ob_re), .out_im(ob_im), .ack(ab));

  // Environment delay lines (read old word, write new word on push)
  logic signed [15:0] ma_re[4], ma_im[4], mb_re[2], mb_im[2];
  int pta = 0, ptb = 0;
  assign ra_re = ma_re[pta];
  assign ra_im = ma_im[pta];
  assign rb_re = mb_re[ptb];
  assign rb_im = mb_im[ptb];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin ma_re[i] <= 16'(i * 37 - 90); ma_im[i] <= 16'(55 - i * 21); end
      for (int i = 0; i < 2; i++) begin mb_re[i] <= 16'(i * 13 + 7); mb_im[i] <= 16'(-i * 9 - 3); end
      pta <= 0; ptb <= 0;
    end else begin
      if (pa) begin ma_re[pta] <= wa_re; ma_im[pta] <= wa_im; pta <= (pta + 1) % 4; end
      if (pb) begin mb_re[ptb] <= wb_re; mb_im[ptb] <= wb_im; ptb <= (ptb + 1) % 2; end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic signed [15:0] w16(input int v);
    return v[15:0];
  endfunction

  int ca = 0, na = 0, cb = 0, nb = 0;

  // Behavioural reference for one stage, evaluated on each cycle before the edge.
  task automatic model(input bit rot, input int nd, input int q, input int frame,
                       inout int c, inout int n,
                       input logic signed [15:0] rd_re, rd_im, wr_re, wr_im, o_re, o_im,
                       input logic ak, input logic pu, input string who);
    int ar, ai, br, bi, t;
    bit sa, sbr;
    string tag;
    logic signed [15:0] eo_r, eo_i, ew_r, ew_i;
    chk(pu == load, "R5", {who, " push"}, pu, load);
    if (!load) begin
      chk(ak == 1'b0, "R3", {who, " idle ack"}, ak, 0);
      return;
    end
    sa  = ((c / nd) % 2) == 0;
    sbr = rot && ((c / q) % 4 == 3);
    ar = rd_re; ai = rd_im; br = in_re; bi = in_im;
    if (sbr) begin
      if (!inverse) begin t = ar; ar = ai;  ai = -t; end
      else          begin t = ar; ar = -ai; ai = t;  end
    end
    if (sa) begin
      eo_r = rd_re; eo_i = rd_im; ew_r = in_re; ew_i = in_im;
      tag = "R1";
    end else begin
      eo_r = w16((ar + br) >>> 1); eo_i = w16((ai + bi) >>> 1);
      ew_r = w16((ar - br) >>> 1); ew_i = w16((ai - bi) >>> 1);
      tag = sbr ? "R6" : "R2";
      if (rd_re == -32768 || rd_im == -32768 || in_re == -32768 || in_im == -32768)
        tag = {tag, "/R7"};
    end
    if (n >= frame) tag = {tag, "/R8"};
    chk(o_re == eo_r, tag, {who, " out_re"}, o_re, eo_r);
    chk(o_im == eo_i, tag, {who, " out_im"}, o_im, eo_i);
    chk(wr_re == ew_r, tag, {who, " dly_wr_re"}, wr_re, ew_r);
    chk(wr_im == ew_i, tag, {who, " dly_wr_im"}, wr_im, ew_i);
    chk(ak == (n >= nd), "R4", {who, " ack"}, ak, (n >= nd));
    c = (c + 1) % frame;
    n++;
  endtask

  task automatic step(input bit ld, input bit inv, input int re, input int im);
    @(negedge clk);
    load = ld; inverse = inv; in_re = 16'(re); in_im = 16'(im);
    #4;
    model(1'b1, 4, 4, 16, ca, na, ra_re, ra_im, wa_re, wa_im, oa_re, oa_im, aa, pa, "rot");
    model(1'b0, 2, 1, 4,  cb, nb, rb_re, rb_im, wb_re, wb_im, ob_re, ob_im, ab, pb, "plain");
  endtask

  function automatic int pick_extreme(input int unsigned r);
    case (r % 4)
      0: return -32768;
      1: return 32767;
      2: return -1;
      default: return 0;
    endcase
  endfunction

  initial begin
    // R9: reset state
    repeat (3) begin
      @(negedge clk); #4;
      chk(aa == 1'b0 && ab == 1'b0, "R9", "ack in reset", aa | ab, 0);
    end
    @(negedge clk); rst_n = 1'b1;
    #4;
    chk(aa == 1'b0 && ab == 1'b0, "R9", "ack after reset", aa | ab, 0);
    step(1'b0, 1'b0, 0, 0);
    step(1'b0, 1'b0, 0, 0);
    // Forward ramp over one full rotation frame
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, i * 1000 - 7000, 3000 - i * 411);
    // R3: loads interleaved with idle cycles, inverse sign
    for (int i = 0; i < 20; i++) step(i % 2 == 0, 1'b1, i * 777 - 5000, -i * 123);
    // R7: full-scale operands, both rotation signs
    for (int i = 0; i < 64; i++)
      step(1'b1, (i / 16) % 2 == 1, pick_extreme($urandom), pick_extreme($urandom));
    for (int i = 0; i < 48; i++)
      step(($urandom % 5) != 0, (i / 8) % 2 == 1, pick_extreme($urandom), pick_extreme($urandom));
    // R8: long run of frames, random data, sign switching every 16 loads
    for (int i = 0; i < 240; i++)
      step(($urandom % 7) != 0, (i / 16) % 2 == 1,
           int'($urandom % 65536) - 32768, int'($urandom % 65536) - 32768);
    step(1'b0, 1'b0, 0, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule